// File: doc/BRIEF.md
# Two-Level Conditional Branch Direction Predictor

This block sits in an instruction prefetch unit and guesses which way a conditional branch will go before it executes. It looks in two places. The first is a small, tagged, direct-mapped branch cache whose entries hold a branch target and a 2-bit direction counter. A hit that predicts taken hands back the target at once, so the prefetcher can fold the branch away at no cycle cost. When that cache has no entry for the address, a larger untagged, direct-mapped table of 2-bit counters gives the direction on its own.

The lookup side is purely combinational on the fetch address. When a branch resolves, the update side receives its address, its outcome, its target and an allocate request. On the next rising clock edge it steps the counters and, when the rules call for it, installs a branch-cache entry.

Top module: `bp_two_level`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) invalidates every branch-cache entry and sets every second-level counter to weakly not-taken. After reset, every lookup reports no hit and predicts not-taken.
- R2: A counter encodes its state as 00 strongly not-taken, 01 weakly not-taken, 10 weakly taken and 11 strongly taken. Bit 1 is the predicted direction (1 = taken).
- R3: Each update moves a counter one step toward the resolved outcome. The counter saturates at 00 and at 11.
- R4: The branch cache is indexed by address bits [3:1]. Its tag is every other address bit. A lookup hits only when the indexed entry is valid and its tag matches, so a second address with the same index but a different tag misses.
- R5: The second-level table is indexed by address bits [7:1] and stores no tag. Addresses that agree in [7:1] share one counter, and addresses that differ there do not.
- R6: An update marked taken with the allocate request set, for an address that misses in the branch cache, overwrites the indexed entry. It stores the tag and the target, sets the state to weakly taken and marks the entry valid. A not-taken update, or one without the allocate request, installs nothing.
- R7: On a branch-cache hit, the direction comes from the entry's counter and the second-level table is ignored. The target output carries the stored target. The fold flag is high exactly when the hit predicts taken.
- R8: On a branch-cache miss, the direction is bit 1 of the indexed second-level counter. Hit, fold and the target output (all zeros) stay low.
- R9: Every update steps the indexed second-level counter, including updates for branches that hit in the branch cache.
- R10: An update that hits in the branch cache steps that entry's counter. A taken outcome also replaces the stored target with the supplied one.
- R11: When a lookup and an update address the same entry in the same cycle, the lookup returns the value from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| lkpAddr | input | ADDR_W | Fetch address of the branch being predicted |
| lkpHit | output | 1 | Branch cache holds a valid, tag-matching entry |
| lkpTaken | output | 1 | Predicted direction, 1 = taken |
| lkpFold | output | 1 | Hit with a taken prediction; target may be folded |
| lkpTarget | output | ADDR_W | Stored target on a hit, zero otherwise |
| updValid | input | 1 | A resolved conditional branch is presented this cycle |
| updAddr | input | ADDR_W | Address of the resolved branch |
| updTaken | input | 1 | Resolved outcome, 1 = taken |
| updTarget | input | ADDR_W | Resolved target address |
| updAlloc | input | 1 | Permission to install the branch in the branch cache |

## Verification
The counters are trained with runs of outcomes that walk each state across the whole range and then reverse. A single opposite outcome that leaves the prediction unchanged shows the counter saturates and has hysteresis, and rules out a wrap or a one-bit counter. Pairs of addresses that share an index are used in both tables: with different tags they show that the branch cache rejects aliases while the second level shares its counter, and an aliased miss shows whether the second level is still trained while the branch cache hits. Updates without the allocate request, not-taken updates and a lookup driven in the same cycle as an allocating update separate the allocation policy from the write timing.

// File: rtl/bp_pkg.sv
package bp_pkg;

  localparam logic [1:0] ST_SNT = 2'b00;
  localparam logic [1:0] ST_WNT = 2'b01;
  localparam logic [1:0] ST_WT  = 2'b10;
  localparam logic [1:0] ST_STK = 2'b11;

  typedef struct packed {
    logic       l1Write;
    logic       l1Fill;
    logic       l1TgtWrite;
    logic [1:0] l1Next;
    logic       l2Write;
    logic [1:0] l2Next;
  } bpStrobes_t;

  function automatic logic [1:0] stepState(input logic [1:0] cur, input logic taken);
    logic [1:0] nxt;
    nxt = cur;
    if (taken && cur != ST_STK) nxt = cur + 2'd1;
    else if (!taken && cur != ST_SNT) nxt = cur - 2'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/bp_datapath.sv
module bp_datapath
  import bp_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int L1_DEPTH = 8,
  parameter int L2_DEPTH = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lkpAddr,
  input  logic [ADDR_W-1:0] updAddr,
  input  logic [ADDR_W-1:0] updTarget,
  input  bpStrobes_t        strb,
  output logic              lkpHit,
  output logic              lkpDir,
  output logic [ADDR_W-1:0] lkpTarget,
  output logic              updL1Hit,
  output logic [1:0]        updL1State,
  output logic [1:0]        updL2State
);

  localparam int L1_IW = $clog2(L1_DEPTH);
  localparam int L2_IW = $clog2(L2_DEPTH);
  localparam int TAG_W = ADDR_W - L1_IW;

  logic              l1Valid [L1_DEPTH];
  logic [TAG_W-1:0]  l1Tag   [L1_DEPTH];
  logic [ADDR_W-1:0] l1Tgt   [L1_DEPTH];
  logic [1:0]        l1St    [L1_DEPTH];
  logic [1:0]        l2St    [L2_DEPTH];

  logic [L1_IW-1:0] lkpL1Idx, updL1Idx;
  logic [L2_IW-1:0] lkpL2Idx, updL2Idx;
  logic [TAG_W-1:0] lkpTag, updTag;

  // bit 0 is zero for aligned branches; keeping it in the tag is harmless
  assign lkpL1Idx = lkpAddr[L1_IW:1];
  assign updL1Idx = updAddr[L1_IW:1];
  assign lkpL2Idx = lkpAddr[L2_IW:1];
  assign updL2Idx = updAddr[L2_IW:1];
  assign lkpTag   = {lkpAddr[ADDR_W-1:L1_IW+1], lkpAddr[0]};
  assign updTag   = {updAddr[ADDR_W-1:L1_IW+1], updAddr[0]};

  // lookup side: reads current contents, so same-cycle updates are not seen
  always_comb begin
    lkpHit    = l1Valid[lkpL1Idx] && (l1Tag[lkpL1Idx] == lkpTag);
    lkpDir    = lkpHit ? l1St[lkpL1Idx][1] : l2St[lkpL2Idx][1];
    lkpTarget = lkpHit ? l1Tgt[lkpL1Idx] : '0;
  end

  // update side readout for the control
  always_comb begin
    updL1Hit   = l1Valid[updL1Idx] && (l1Tag[updL1Idx] == updTag);
    updL1State = l1St[updL1Idx];
    updL2State = l2St[updL2Idx];
  end

  for (genvar g = 0; g < L1_DEPTH; g++) begin : gL1
    logic sel;
    assign sel = (updL1Idx == L1_IW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        l1Valid[g] <= 1'b0;
      end else if (sel && strb.l1Fill) begin
        l1Valid[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel && strb.l1Fill) l1Tag[g] <= updTag;
      if (sel && strb.l1TgtWrite) l1Tgt[g] <= updTarget;
      if (rst) l1St[g] <= ST_SNT;
      else if (sel && strb.l1Write) l1St[g] <= strb.l1Next;
    end
  end

  for (genvar g = 0; g < L2_DEPTH; g++) begin : gL2
    always_ff @(posedge clk) begin
      if (rst) l2St[g] <= ST_WNT;
      else if (strb.l2Write && updL2Idx == L2_IW'(g)) l2St[g] <= strb.l2Next;
    end
  end

endmodule

// File: rtl/bp_control.sv
module bp_control
  import bp_pkg::*;
(
  input  logic       updValid,
  input  logic       updTaken,
  input  logic       updAlloc,
  input  logic       updL1Hit,
  input  logic [1:0] updL1State,
  input  logic [1:0] updL2State,
  input  logic       lkpHit,
  input  logic       lkpDir,
  output bpStrobes_t strb,
  output logic       lkpFold
);

  logic fillNow;

  always_comb begin
    fillNow         = updValid && !updL1Hit && updTaken && updAlloc;
    strb.l1Fill     = fillNow;
    strb.l1Write    = fillNow || (updValid && updL1Hit);
    strb.l1TgtWrite = fillNow || (updValid && updL1Hit && updTaken);
    strb.l1Next     = fillNow ? ST_WT : stepState(updL1State, updTaken);
    strb.l2Write    = updValid;
    strb.l2Next     = stepState(updL2State, updTaken);
    lkpFold         = lkpHit && lkpDir;
  end

endmodule

// File: rtl/bp_two_level.sv
module bp_two_level
  import bp_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int L1_DEPTH = 8,
  parameter int L2_DEPTH = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lkpAddr,
  output logic              lkpHit,
  output logic              lkpTaken,
  output logic              lkpFold,
  output logic [ADDR_W-1:0] lkpTarget,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updAddr,
  input  logic              updTaken,
  input  logic [ADDR_W-1:0] updTarget,
  input  logic              updAlloc
);

  bpStrobes_t strb;
  logic       updL1Hit;
  logic [1:0] updL1State, updL2State;

  bp_datapath #(
    .ADDR_W  (ADDR_W),
    .L1_DEPTH(L1_DEPTH),
    .L2_DEPTH(L2_DEPTH)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .lkpAddr   (lkpAddr),
    .updAddr   (updAddr),
    .updTarget (updTarget),
    .strb      (strb),
    .lkpHit    (lkpHit),
    .lkpDir    (lkpTaken),
    .lkpTarget (lkpTarget),
    .updL1Hit  (updL1Hit),
    .updL1State(updL1State),
    .updL2State(updL2State)
  );

  bp_control u_ctl (
    .updValid  (updValid),
    .updTaken  (updTaken),
    .updAlloc  (updAlloc),
    .updL1Hit  (updL1Hit),
    .updL1State(updL1State),
    .updL2State(updL2State),
    .lkpHit    (lkpHit),
    .lkpDir    (lkpTaken),
    .strb      (strb),
    .lkpFold   (lkpFold)
  );

endmodule

// File: rtl/bp_two_level_chk.sv
module bp_two_level_chk #(
  parameter int ADDR_W   = 32,
  parameter int L2_DEPTH = 128
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] lkpAddr,
  input logic              lkpHit,
  input logic              lkpTaken,
  input logic              lkpFold,
  input logic [ADDR_W-1:0] lkpTarget,
  input logic              updValid,
  input logic [ADDR_W-1:0] updAddr,
  input logic              updTaken,
  input logic [ADDR_W-1:0] updTarget,
  input logic              updAlloc
);

  localparam int L2_IW = $clog2(L2_DEPTH);

  logic sameL2;
  assign sameL2 = (lkpAddr[L2_IW:1] == updAddr[L2_IW:1]);

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !lkpHit); // R1

  AST_FOLD_NEEDS_TAKEN_HIT: assert property (@(posedge clk) disable iff (rst)
    lkpFold |-> (lkpHit && lkpTaken)); // R7

  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !lkpHit |-> (lkpTarget == '0 && !lkpFold)); // R8

  AST_ALLOC_THEN_HIT: assert property (@(posedge clk) disable iff (rst)
    (updValid && updTaken && updAlloc && !lkpHit && lkpAddr == updAddr)
    |=> (!$stable(lkpAddr) || (lkpHit && lkpTaken && lkpTarget == $past(updTarget)))); // R6

  AST_L2_TAKEN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (updValid && updTaken && !lkpHit && lkpTaken && sameL2)
    |=> (!$stable(lkpAddr) || lkpHit || lkpTaken)); // R3

  AST_L2_NT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (updValid && !updTaken && !updAlloc && !lkpHit && !lkpTaken && sameL2)
    |=> (!$stable(lkpAddr) || lkpHit || !lkpTaken)); // R3

endmodule

bind bp_two_level bp_two_level_chk #(
  .ADDR_W  (ADDR_W),
  .L2_DEPTH(L2_DEPTH)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .lkpAddr  (lkpAddr),
  .lkpHit   (lkpHit),
  .lkpTaken (lkpTaken),
  .lkpFold  (lkpFold),
  .lkpTarget(lkpTarget),
  .updValid (updValid),
  .updAddr  (updAddr),
  .updTaken (updTaken),
  .updTarget(updTarget),
  .updAlloc (updAlloc)
);

// File: tb/tb_bp_two_level.sv
module tb_bp_two_level;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] lkpAddr = '0;
  logic              lkpHit, lkpTaken, lkpFold;
  logic [ADDR_W-1:0] lkpTarget;
  logic              updValid = 1'b0;
  logic [ADDR_W-1:0] updAddr = '0;
  logic              updTaken = 1'b0;
  logic [ADDR_W-1:0] updTarget = '0;
  logic              updAlloc = 1'b0;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bp_two_level #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .lkpAddr(lkpAddr), .lkpHit(lkpHit), .lkpTaken(lkpTaken),
    .lkpFold(lkpFold), .lkpTarget(lkpTarget), .updValid(updValid), .updAddr(updAddr),
    .updTaken(updTaken), .updTarget(updTarget), .updAlloc(updAlloc)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expectLook(input string req, input logic [31:0] addr, input logic hit,
                            input logic taken, input logic fold, input logic [31:0] tgt);
    lkpAddr = addr;
    #1;
    chk(req, "hit", 32'(lkpHit), 32'(hit));
    chk(req, "taken", 32'(lkpTaken), 32'(taken));
    chk(req, "fold", 32'(lkpFold), 32'(fold));
    chk(req, "target", lkpTarget, tgt);
  endtask

  task automatic doUpd(input logic [31:0] addr, input logic taken, input logic [31:0] tgt, input logic alloc);
    @(negedge clk);
    updValid = 1'b1; updAddr = addr; updTaken = taken; updTarget = tgt; updAlloc = alloc;
    @(negedge clk);
    updValid = 1'b0; updAlloc = 1'b0; updTaken = 1'b0;
  endtask

  task automatic tReset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    expectLook("R1", 32'h0000_0100, 1'b0, 1'b0, 1'b0, 32'h0);
    expectLook("R1", 32'h0000_0040, 1'b0, 1'b0, 1'b0, 32'h0);
  endtask

  // second level alone: R2, R3, R5, R8
  task automatic tL2Training();
    doUpd(32'h40, 1'b1, 32'h0, 1'b0);               // 01 -> 10
    expectLook("R8", 32'h40, 1'b0, 1'b1, 1'b0, 32'h0);
    expectLook("R5", 32'h42, 1'b0, 1'b0, 1'b0, 32'h0); // other index untouched
    doUpd(32'h40, 1'b1, 32'h0, 1'b0);               // 11
    doUpd(32'h40, 1'b1, 32'h0, 1'b0);               // stays 11
    doUpd(32'h40, 1'b0, 32'h0, 1'b0);               // 10
    expectLook("R3", 32'h40, 1'b0, 1'b1, 1'b0, 32'h0);
    doUpd(32'h40, 1'b0, 32'h0, 1'b0);               // 01
    expectLook("R2", 32'h40, 1'b0, 1'b0, 1'b0, 32'h0);
    doUpd(32'h1040, 1'b1, 32'h0, 1'b0);             // alias shares counter -> 10
    expectLook("R5", 32'h40, 1'b0, 1'b1, 1'b0, 32'h0);
  endtask

  // allocation and tag compare: R4, R6, R7
  task automatic tAllocate();
    expectLook("R6", 32'h100, 1'b0, 1'b0, 1'b0, 32'h0);
    doUpd(32'h100, 1'b1, 32'h8000, 1'b1);
    expectLook("R6", 32'h100, 1'b1, 1'b1, 1'b1, 32'h8000);
    expectLook("R4", 32'h300, 1'b0, 1'b1, 1'b0, 32'h0); // same index, other tag; L2 idx 0 now 10
    expectLook("R4", 32'h102, 1'b0, 1'b0, 1'b0, 32'h0);
  endtask

  // branch-cache counter walk: R3, R7, R10
  task automatic tL1Hysteresis();
    doUpd(32'h100, 1'b0, 32'h0, 1'b0);              // L1 10->01
    expectLook("R7", 32'h100, 1'b1, 1'b0, 1'b0, 32'h8000);
    doUpd(32'h100, 1'b0, 32'h0, 1'b0);              // 00
    doUpd(32'h100, 1'b1, 32'h8000, 1'b0);           // 01
    expectLook("R3", 32'h100, 1'b1, 1'b0, 1'b0, 32'h8000);
    doUpd(32'h100, 1'b1, 32'h8000, 1'b0);           // 10
    doUpd(32'h100, 1'b1, 32'h8000, 1'b0);           // 11
    doUpd(32'h100, 1'b0, 32'h0, 1'b0);              // 10
    expectLook("R10", 32'h100, 1'b1, 1'b1, 1'b1, 32'h8000);
  endtask

  // second level still trained under a hit: R9 (L2 idx 0 is 10 here)
  task automatic tL2OnHit();
    doUpd(32'h100, 1'b0, 32'h0, 1'b0);
    doUpd(32'h100, 1'b0, 32'h0, 1'b0);
    expectLook("R9", 32'h300, 1'b0, 1'b0, 1'b0, 32'h0);
    expectLook("R7", 32'h100, 1'b1, 1'b0, 1'b0, 32'h8000);
  endtask

  task automatic tNoAlloc();
    doUpd(32'h204, 1'b1, 32'hA000, 1'b0);
    expectLook("R6", 32'h204, 1'b0, 1'b1, 1'b0, 32'h0);
    doUpd(32'h204, 1'b0, 32'hA000, 1'b1);
    expectLook("R6", 32'h204, 1'b0, 1'b0, 1'b0, 32'h0);
    doUpd(32'h204, 1'b1, 32'hA000, 1'b1);
    expectLook("R6", 32'h204, 1'b1, 1'b1, 1'b1, 32'hA000);
  endtask

  task automatic tTargetRefresh();
    doUpd(32'h204, 1'b1, 32'hB000, 1'b1);
    expectLook("R10", 32'h204, 1'b1, 1'b1, 1'b1, 32'hB000);
    doUpd(32'h1204, 1'b1, 32'hC000, 1'b1);          // evicts same index
    expectLook("R4", 32'h1204, 1'b1, 1'b1, 1'b1, 32'hC000);
    lkpAddr = 32'h204; #1;
    chk("R4", "evicted hit", 32'(lkpHit), 32'h0);
  endtask

  task automatic tSameCycle();
    @(negedge clk);
    updValid = 1'b1; updAddr = 32'h8; updTaken = 1'b1; updTarget = 32'hD000; updAlloc = 1'b1;
    lkpAddr = 32'h8;
    #1;
    chk("R11", "hit before edge", 32'(lkpHit), 32'h0);
    chk("R11", "target before edge", lkpTarget, 32'h0);
    @(posedge clk); #1;
    chk("R11", "hit after edge", 32'(lkpHit), 32'h1);
    chk("R11", "target after edge", lkpTarget, 32'hD000);
    @(negedge clk);
    updValid = 1'b0; updAlloc = 1'b0; updTaken = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    tReset();
    tL2Training();
    tAllocate();
    tL1Hysteresis();
    tL2OnHit();
    tNoAlloc();
    tTargetRefresh();
    tSameCycle();
    tReset();
    summary();
  end

endmodule